// File: doc/BRIEF.md
# Serial TDM Channel Port

This block is a slave port on a 2.048 Mbit/s serial time-division stream whose 4.096 MHz bit clock and active-low frame pulse come from outside. Every bit cell spans two clock cycles. A frame holds 32 eight-bit timeslots, which is 512 clock cycles. The port claims only the first four timeslots. Slot 0 carries the D channel, slot 1 the C channel, slot 2 B1 and slot 3 B2. In those slots it shifts received bits into four parallel bytes and drives four parallel transmit bytes onto the serial output. For the other 28 slots it releases the output.

At the boundary after slot 3 it emits a one-cycle delayed frame pulse. A second port wired to that pulse takes the following four slots of the same stream. A half-frame select input is latched at every frame start. The latched value is readable as a port and is also carried on the top bit of the outgoing C byte, which is the status channel. When frame pulses stop arriving, a loss-of-frame flag rises and the port stays silent until a pulse returns.

Top module: `tdm_channel_port`

## Requirements
- R1: After reset, ser_oe is 0, ser_out is 0, dfp_n is 1, rx_valid is 0, lof is 1, half_flag is 0 and all four received bytes are 0.
- R2: When frame_n is sampled low at a rising clock edge, the next clock cycle is cycle 0 of a new frame. A frame lasts 512 cycles. A pulse that arrives early restarts the frame at cycle 0.
- R3: In cycles 0 to 63, ser_out carries the 32 bits of D, C, B1 and B2 in that order, most significant bit first. Each bit is held for two cycles, so bit k of the stream occupies cycles 2k and 2k+1.
- R4: ser_oe is 1 in cycles 0 to 63 and 0 in cycles 64 to 511. While ser_oe is 0, ser_out is 0.
- R5: The transmit bytes are captured at the rising edge that samples the frame pulse. Changes to tx_d, tx_c, tx_b1 or tx_b2 after that edge have no effect until the next frame.
- R6: ser_in is sampled at the rising edge that ends the second cycle of each bit cell in cycles 0 to 63. The first bit received becomes bit 7 of rx_d, and the last becomes bit 0 of rx_b2.
- R7: rx_d, rx_c, rx_b1 and rx_b2 all update at the edge that ends cycle 63. rx_valid is 1 for exactly cycle 64. The received bytes do not change at any other time.
- R8: dfp_n is 0 for exactly one cycle, cycle 63, in every aligned frame.
- R9: half_sel is latched into half_flag at the edge that samples the frame pulse. The same value replaces bit 7 of tx_c in the outgoing C byte of that frame.
- R10: If no frame pulse arrives within 512 cycles after the previous one, lof goes to 1. While lof is 1, ser_oe is 0, dfp_n is 1, rx_valid stays 0 and the received bytes hold. The next frame pulse clears lof, and that frame runs normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 4.096 MHz bit clock |
| rst | input | 1 | Synchronous reset, active high |
| frame_n | input | 1 | Frame pulse, active low |
| ser_in | input | 1 | Serial receive data |
| half_sel | input | 1 | Half-frame select, latched at frame start |
| tx_d | input | 8 | D byte to transmit |
| tx_c | input | 8 | C (control) byte to transmit; bit 7 is replaced by the half flag |
| tx_b1 | input | 8 | B1 byte to transmit |
| tx_b2 | input | 8 | B2 byte to transmit |
| ser_out | output | 1 | Serial transmit data |
| ser_oe | output | 1 | Output enable for ser_out; 0 means high impedance |
| dfp_n | output | 1 | Delayed frame pulse for the next port, active low |
| rx_d | output | 8 | Received D byte |
| rx_c | output | 8 | Received C byte |
| rx_b1 | output | 8 | Received B1 byte |
| rx_b2 | output | 8 | Received B2 byte |
| rx_valid | output | 1 | One-cycle strobe for new received bytes |
| half_flag | output | 1 | Half-frame select latched at the last frame start |
| lof | output | 1 | Loss of frame |

## Verification
A slot counter that is off by even one cycle moves the enable window and the delayed pulse in the same frame. That shows as a mismatch at cycle 0 or cycle 63, and the serialized bits shift out of place. A wrong bit index or sample phase corrupts either ser_out within the first 64 cycles or the byte presented with rx_valid at cycle 64, so it is caught in the frame where it happens. A fault in the loss-of-frame timer shows within one cycle of the missed pulse, because the counter wraps and would otherwise re-enable the output. A transmit latch that is open at the wrong time shows only in a frame where the parallel inputs change after the pulse, so the bench changes them in every frame.

// File: rtl/tdm_pkg.sv
package tdm_pkg;

    localparam int CYC_PER_BIT  = 2;
    localparam int CHAN_BITS    = 8;
    localparam int FRAME_SLOTS  = 32;
    localparam int OWN_SLOTS    = 4;

    localparam int CYC_PER_SLOT = CYC_PER_BIT * CHAN_BITS;
    localparam int FRAME_CYC    = CYC_PER_SLOT * FRAME_SLOTS;
    localparam int ACTIVE_CYC   = CYC_PER_SLOT * OWN_SLOTS;
    localparam int WORD_BITS    = CHAN_BITS * OWN_SLOTS;
    localparam int CNT_W        = $clog2(FRAME_CYC);
    localparam int POS_W        = $clog2(WORD_BITS);

    typedef logic [CNT_W-1:0]     cnt_t;
    typedef logic [POS_W-1:0]     pos_t;
    typedef logic [CHAN_BITS-1:0] chan_t;

    // Slot order on the wire; the first field is sent first.
    typedef struct packed {
        chan_t d;
        chan_t c;
        chan_t b1;
        chan_t b2;
    } chan_set_t;

    typedef struct packed {
        logic active;  // inside the four owned slots
        logic sample;  // second cycle of a bit cell
        logic last;    // final cycle of the owned window
        pos_t pos;     // bit index within the owned window
    } phase_t;

    function automatic phase_t decode_phase(cnt_t cnt);
        phase_t ph;
        ph.active = (cnt < CNT_W'(ACTIVE_CYC));
        ph.sample = ((cnt % CNT_W'(CYC_PER_BIT)) == CNT_W'(CYC_PER_BIT - 1));
        ph.last   = (cnt == CNT_W'(ACTIVE_CYC - 1));
        ph.pos    = POS_W'(cnt / CNT_W'(CYC_PER_BIT));
        return ph;
    endfunction

endpackage

// File: rtl/tdm_frame_timer.sv
module tdm_frame_timer
    import tdm_pkg::*;
#(
    parameter int LOF_LIMIT = FRAME_CYC
) (
    input  logic clk,
    input  logic rst,
    input  logic frame_n,
    input  logic half_sel,
    output cnt_t cnt,
    output logic fp_hit,
    output logic lof,
    output logic half_q
);
    localparam int SINCE_W = $clog2(LOF_LIMIT);

    logic [SINCE_W-1:0] since_q;

    assign fp_hit = !frame_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            since_q <= '0;
            lof     <= 1'b1;
            half_q  <= 1'b0;
        end else if (fp_hit) begin
            cnt     <= '0;
            since_q <= '0;
            lof     <= 1'b0;
            half_q  <= half_sel;
        end else begin
            cnt <= (cnt == CNT_W'(FRAME_CYC - 1)) ? '0 : cnt + 1'b1;
            if (since_q == SINCE_W'(LOF_LIMIT - 1))
                lof <= 1'b1;
            else
                since_q <= since_q + 1'b1;
        end
    end

endmodule

// File: rtl/tdm_tx_serializer.sv
module tdm_tx_serializer
    import tdm_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      fp_hit,
    input  logic      half_sel,
    input  chan_set_t tx_in,
    input  logic      active,
    input  pos_t      pos,
    input  logic      lof,
    output logic      ser_out,
    output logic      ser_oe
);
    chan_set_t             tx_q;
    logic [WORD_BITS-1:0]  tx_vec;

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_q <= '0;
        end else if (fp_hit) begin
            tx_q.d  <= tx_in.d;
            tx_q.c  <= {half_sel, tx_in.c[CHAN_BITS-2:0]};
            tx_q.b1 <= tx_in.b1;
            tx_q.b2 <= tx_in.b2;
        end
    end

    assign tx_vec  = tx_q;
    assign ser_oe  = active && !lof;
    assign ser_out = ser_oe && tx_vec[POS_W'(WORD_BITS - 1) - pos];

endmodule

// File: rtl/tdm_rx_deserializer.sv
module tdm_rx_deserializer
    import tdm_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      ser_in,
    input  logic      active,
    input  logic      sample,
    input  logic      last,
    input  logic      lof,
    output chan_set_t rx_out,
    output logic      rx_valid
);
    logic [WORD_BITS-1:0] shift_q;
    logic [WORD_BITS-1:0] shift_nx;
    logic                 take;

    assign take     = active && sample && !lof;
    assign shift_nx = {shift_q[WORD_BITS-2:0], ser_in};

    always_ff @(posedge clk) begin
        if (rst) begin
            shift_q  <= '0;
            rx_out   <= '0;
            rx_valid <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            if (take) begin
                shift_q <= shift_nx;
                if (last) begin
                    rx_out   <= shift_nx;
                    rx_valid <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/tdm_channel_port.sv
module tdm_channel_port
    import tdm_pkg::*;
#(
    parameter int LOF_LIMIT = FRAME_CYC
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 frame_n,
    input  logic                 ser_in,
    input  logic                 half_sel,
    input  logic [CHAN_BITS-1:0] tx_d,
    input  logic [CHAN_BITS-1:0] tx_c,
    input  logic [CHAN_BITS-1:0] tx_b1,
    input  logic [CHAN_BITS-1:0] tx_b2,
    output logic                 ser_out,
    output logic                 ser_oe,
    output logic                 dfp_n,
    output logic [CHAN_BITS-1:0] rx_d,
    output logic [CHAN_BITS-1:0] rx_c,
    output logic [CHAN_BITS-1:0] rx_b1,
    output logic [CHAN_BITS-1:0] rx_b2,
    output logic                 rx_valid,
    output logic                 half_flag,
    output logic                 lof
);
    cnt_t      cnt;
    logic      fp_hit;
    phase_t    ph;
    chan_set_t tx_set;
    chan_set_t rx_set;

    tdm_frame_timer #(.LOF_LIMIT(LOF_LIMIT)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .frame_n  (frame_n),
        .half_sel (half_sel),
        .cnt      (cnt),
        .fp_hit   (fp_hit),
        .lof      (lof),
        .half_q   (half_flag)
    );

    assign ph = decode_phase(cnt);

    assign tx_set.d  = tx_d;
    assign tx_set.c  = tx_c;
    assign tx_set.b1 = tx_b1;
    assign tx_set.b2 = tx_b2;

    tdm_tx_serializer u_tx (
        .clk      (clk),
        .rst      (rst),
        .fp_hit   (fp_hit),
        .half_sel (half_sel),
        .tx_in    (tx_set),
        .active   (ph.active),
        .pos      (ph.pos),
        .lof      (lof),
        .ser_out  (ser_out),
        .ser_oe   (ser_oe)
    );

    tdm_rx_deserializer u_rx (
        .clk      (clk),
        .rst      (rst),
        .ser_in   (ser_in),
        .active   (ph.active),
        .sample   (ph.sample),
        .last     (ph.last),
        .lof      (lof),
        .rx_out   (rx_set),
        .rx_valid (rx_valid)
    );

    assign rx_d  = rx_set.d;
    assign rx_c  = rx_set.c;
    assign rx_b1 = rx_set.b1;
    assign rx_b2 = rx_set.b2;

    // Handover pulse for the next port, in the last cycle of the owned window.
    assign dfp_n = !(ph.last && !lof);

endmodule

// File: rtl/tdm_channel_port_chk.sv
module tdm_channel_port_chk (
    input logic        clk,
    input logic        rst,
    input logic        frame_n,
    input logic        ser_oe,
    input logic        dfp_n,
    input logic        rx_valid,
    input logic        lof,
    input logic        half_flag,
    input logic [31:0] rx_word
);

    // R10: a lost frame keeps the port silent
    assert_lof_silent_R10: assert property (@(posedge clk) disable iff (rst)
        lof |-> (!ser_oe && dfp_n && !rx_valid));

    // R10: a frame pulse restores alignment
    assert_pulse_clears_lof_R10: assert property (@(posedge clk) disable iff (rst)
        !frame_n |=> !lof);

    // R8: the handover pulse falls inside the driven window
    assert_dfp_in_window_R8: assert property (@(posedge clk) disable iff (rst)
        !dfp_n |-> ser_oe);

    // R4: the output is released right after the handover
    assert_release_after_dfp_R4: assert property (@(posedge clk) disable iff (rst)
        (!dfp_n && frame_n) |=> !ser_oe);

    // R7: the valid strobe lasts one cycle
    assert_valid_single_R7: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid);

    // R7: new bytes appear only after the handover cycle
    assert_valid_after_dfp_R7: assert property (@(posedge clk) disable iff (rst)
        rx_valid |-> $past(!dfp_n));

    // R7: received bytes hold between strobes
    assert_rx_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !rx_valid |-> $stable(rx_word));

    // R9: the half flag moves only after a frame pulse
    assert_half_on_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        !$stable(half_flag) |-> $past(!frame_n));

endmodule

bind tdm_channel_port tdm_channel_port_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .frame_n   (frame_n),
    .ser_oe    (ser_oe),
    .dfp_n     (dfp_n),
    .rx_valid  (rx_valid),
    .lof       (lof),
    .half_flag (half_flag),
    .rx_word   ({rx_d, rx_c, rx_b1, rx_b2})
);

// File: tb/tb_tdm_channel_port.sv
module tb_tdm_channel_port;

    localparam int CLK_PERIOD = 10;
    localparam int FRAME      = 512;
    localparam int ACTIVE     = 64;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       frame_n = 1'b1;
    logic       ser_in = 1'b0;
    logic       half_sel = 1'b0;
    logic [7:0] tx_d = '0, tx_c = '0, tx_b1 = '0, tx_b2 = '0;
    logic       ser_out, ser_oe, dfp_n, rx_valid, half_flag, lof;
    logic [7:0] rx_d, rx_c, rx_b1, rx_b2;

    int n_checks = 0;
    int n_errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tdm_channel_port dut (
        .clk(clk), .rst(rst), .frame_n(frame_n), .ser_in(ser_in),
        .half_sel(half_sel), .tx_d(tx_d), .tx_c(tx_c), .tx_b1(tx_b1),
        .tx_b2(tx_b2), .ser_out(ser_out), .ser_oe(ser_oe), .dfp_n(dfp_n),
        .rx_d(rx_d), .rx_c(rx_c), .rx_b1(rx_b1), .rx_b2(rx_b2),
        .rx_valid(rx_valid), .half_flag(half_flag), .lof(lof)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] tx_expect(logic [31:0] txv, logic hs);
        logic [31:0] e = txv;
        e[23] = hs;  // bit 7 of the C byte carries the half flag
        return e;
    endfunction

    function automatic logic [31:0] rx_word();
        return {rx_d, rx_c, rx_b1, rx_b2};
    endfunction

    // Entered at a falling edge: this cycle carries the frame pulse.
    task automatic do_frame(input logic [31:0] txv, input logic [31:0] rxv,
                            input logic hs, input int len);
        logic [31:0] exp_tx = tx_expect(txv, hs);
        {tx_d, tx_c, tx_b1, tx_b2} = txv;
        half_sel = hs;
        frame_n  = 1'b0;
        for (int c = 0; c < len; c++) begin
            @(negedge clk);
            if (c == 0) begin
                frame_n  = 1'b1;
                half_sel = $urandom();
                chk(half_flag == hs, "R9 half_flag", 32'(half_flag), 32'(hs));
                chk(lof == 1'b0, "R10 lof clear", 32'(lof), 0);
                chk(ser_oe == 1'b1, "R2 frame start", 32'(ser_oe), 1);
            end
            if (c == 20) {tx_d, tx_c, tx_b1, tx_b2} = $urandom();
            chk(ser_oe == (c < ACTIVE), "R4 ser_oe", 32'(ser_oe), 32'(c < ACTIVE));
            if (c < ACTIVE)
                chk(ser_out == exp_tx[31 - c/2], (c > 20) ? "R5 ser_out" : "R3 ser_out",
                    32'(ser_out), 32'(exp_tx[31 - c/2]));
            else
                chk(ser_out == 1'b0, "R4 ser_out idle", 32'(ser_out), 0);
            chk(dfp_n == (c != ACTIVE - 1), "R8 dfp_n", 32'(dfp_n), 32'(c != ACTIVE - 1));
            chk(rx_valid == (c == ACTIVE), "R7 rx_valid", 32'(rx_valid), 32'(c == ACTIVE));
            if (c == ACTIVE) chk(rx_word() == rxv, "R6 rx bytes", rx_word(), rxv);
            if (c == 200)    chk(rx_word() == rxv, "R7 rx hold", rx_word(), rxv);
            ser_in = (c < ACTIVE) ? rxv[31 - c/2] : 1'($urandom());
        end
    endtask

    task automatic idle_lost(input int n, input logic [31:0] held);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            ser_in = $urandom();
            chk(lof == 1'b1, "R10 lof set", 32'(lof), 1);
            chk(!ser_oe && dfp_n && !rx_valid, "R10 silent",
                {ser_oe, dfp_n, rx_valid}, 32'b010);
        end
        chk(rx_word() == held, "R10 rx held", rx_word(), held);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd24681357));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(ser_oe == 0 && ser_out == 0 && dfp_n == 1, "R1 outputs",
            {ser_oe, ser_out, dfp_n}, 32'b001);
        chk(rx_valid == 0 && lof == 1 && half_flag == 0, "R1 flags",
            {rx_valid, lof, half_flag}, 32'b010);
        chk(rx_word() == 0, "R1 rx bytes", rx_word(), 0);

        // directed patterns
        do_frame(32'hFFFF_FFFF, 32'hA5C3_0F81, 1'b1, FRAME);
        do_frame(32'h0000_0000, 32'h0000_0001, 1'b0, FRAME);
        do_frame(32'h8001_7E55, 32'h8000_0000, 1'b1, FRAME);
        // random frames
        for (int f = 0; f < 8; f++)
            do_frame($urandom(), $urandom(), 1'($urandom()), FRAME);
        // early pulse restarts the frame (R2)
        do_frame($urandom(), $urandom(), 1'b0, 300);
        do_frame($urandom(), 32'h1234_5678, 1'b1, FRAME);
        // missing pulse (R10)
        idle_lost(120, 32'h1234_5678);
        do_frame($urandom(), $urandom(), 1'b0, FRAME);
        do_frame($urandom(), $urandom(), 1'b1, FRAME);

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule